// File: doc/BRIEF.md
# Pulsed Overcurrent Protection Controller

This block is the per-channel decision logic behind a supply output's short-circuit protection. It watches a raw overload-detect flag from the analog current sensor and decides whether the channel's output stage may conduct. It also raises a one-cycle request to set the channel's overload diagnostic bit and, when the recovery policy demands it, a one-cycle request to clear the channel's voltage-select field. An active-low fault pin follows the protection state. The timers for the on and off windows advance only on a prescaled tick, which is nominally one millisecond.

Two register bits steer the behaviour. The limiting-mode bit selects pulsed limiting or a static current clamp. In pulsed mode a sustained overload makes the output run for an on-window, then stay off for an off-window, then retry. In static mode the output keeps conducting and only the diagnostics are raised. The recovery bit decides what happens after the overload has gone. The channel either returns to normal by itself or stays disabled until software writes the voltage-select field again, which is signalled by a rearm pulse. The overload flag crosses into the clock domain through a two-flop synchroniser, and it must stay asserted for a set number of consecutive cycles before it counts as a detection.

Top module: `olp_ctrl`

## Requirements
- R1: After reset, out_en=1, fault_n=1, olf_set=0 and vsel_clr=0.
- R2: After two synchroniser stages, ovl_raw must stay high for HOLD_CYC consecutive clock cycles to count as a detection. A shorter pulse changes no output. When the hold is met, the outputs react HOLD_CYC+3 cycles after ovl_raw rises.
- R3: On the first detection from normal operation, olf_set pulses high for exactly one cycle and fault_n goes low in the same cycle. This holds in both limiting modes.
- R4: With pcl_static=0, out_en stays 1 for TON_TICKS ticks after detection and then goes 0 for TOFF_TICKS ticks.
- R5: After the off-window, out_en returns to 1 for a retry window of TON_TICKS ticks. If an overload is detected at any point in that window, out_en goes 0 for another off-window.
- R6: If a retry window passes with no detection and olr_latch=0, the channel returns to normal with out_en=1 and fault_n=1.
- R7: With pcl_static=1, out_en never goes to 0 because of an overload. fault_n stays low while the overload is detected and goes high one cycle after the detection clears, when olr_latch=0.
- R8: When the channel recovers with olr_latch=1, vsel_clr pulses for one cycle. out_en then stays 0 and fault_n stays 0 until a vsel_rearm pulse, and the channel is normal on the following cycle. vsel_rearm has no effect in normal operation.
- R9: The window timers advance only on cycles where tick=1. Without ticks, a window never ends.
- R10: pcl_static is sampled only at window boundaries. An off-window in progress always runs its full length. If the mode is static at the end of a window that saw an overload, the channel enters the clamp and out_en stays 1. Clearing pcl_static during a clamp with the overload still present starts a fresh on-window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled timer tick, one cycle wide |
| ovl_raw | input | 1 | Asynchronous overload flag from the current sensor |
| pcl_static | input | 1 | 1 = static clamp, 0 = pulsed limiting |
| olr_latch | input | 1 | 1 = stay disabled after an overload until rearm |
| vsel_rearm | input | 1 | Pulse: software has rewritten the voltage-select field |
| out_en | output | 1 | Output stage may conduct |
| olf_set | output | 1 | One-cycle request to set the overload diagnostic bit |
| vsel_clr | output | 1 | One-cycle request to clear the voltage-select field |
| fault_n | output | 1 | Active-low fault indication |

## Verification
A detection shows at the outputs HOLD_CYC+3 cycles after ovl_raw rises. That count is two synchroniser flops, the hold counter, the detection register and the registered outputs. Each window edge appears exactly TON_TICKS or TOFF_TICKS cycles after the previous boundary when tick is held high. A cleared detection reaches the state one cycle after the filter drops, which is four cycles after ovl_raw falls. The bench drives every input on the falling edge. It advances a whole number of falling edges derived from these counts, and it samples one cycle before and at each expected transition, so an off-by-one error in either direction is caught.

// File: rtl/olp_pkg.sv
`timescale 1ns/1ps
package olp_pkg;

  typedef enum logic [2:0] {
    ST_NORM  = 3'd0,
    ST_ONW   = 3'd1,
    ST_OFFW  = 3'd2,
    ST_RETRY = 3'd3,
    ST_CLAMP = 3'd4,
    ST_LOCK  = 3'd5
  } olp_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/olp_ovl_filter.sv
`timescale 1ns/1ps
module olp_ovl_filter #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ovl_raw,
  output logic ovl_det
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] RUN_LAST = CW'(HOLD_CYC - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= '0;
      run_q   <= '0;
      ovl_det <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ovl_raw};
      if (!sync_q[1]) begin
        run_q   <= '0;
        ovl_det <= 1'b0;
      end else if (run_q == RUN_LAST) begin
        ovl_det <= 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R2: detection only follows a synchronised high level
  p_det_needs_sync_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ovl_det) |-> $past(sync_q[1]));
  p_low_clears_det_r2: assert property (@(posedge clk) disable iff (rst)
    !sync_q[1] |=> !ovl_det);

endmodule

// File: rtl/olp_tick_timer.sv
`timescale 1ns/1ps
module olp_tick_timer #(
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  assign done = tick && (cnt_q == limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end

  // R9: count moves only on a tick
  p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(cnt_q));
  p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (rst)
    (limit != '0) |-> (cnt_q < limit));

endmodule

// File: rtl/olp_fsm.sv
`timescale 1ns/1ps
module olp_fsm
  import olp_pkg::*;
#(
  parameter int TON_TICKS  = 90,
  parameter int TOFF_TICKS = 900,
  parameter int TW         = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ovl_det,
  input  logic          pcl_static,
  input  logic          olr_latch,
  input  logic          vsel_rearm,
  input  logic          tmr_done,
  output logic          tmr_clr,
  output logic [TW-1:0] tmr_limit,
  output logic          out_en,
  output logic          fault_n,
  output logic          olf_set,
  output logic          vsel_clr
);
  olp_state_e state_q, state_d;
  logic       hit_q, hit_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORM: begin
        if (ovl_det) state_d = pcl_static ? ST_CLAMP : ST_ONW;
      end
      ST_ONW, ST_RETRY: begin
        if (tmr_done) begin
          if (hit_q || ovl_det) state_d = pcl_static ? ST_CLAMP : ST_OFFW;
          else                  state_d = olr_latch ? ST_LOCK : ST_NORM;
        end
      end
      ST_OFFW: begin
        if (tmr_done) state_d = ST_RETRY;
      end
      ST_CLAMP: begin
        if (!ovl_det)        state_d = olr_latch ? ST_LOCK : ST_NORM;
        else if (!pcl_static) state_d = ST_ONW;
      end
      ST_LOCK: begin
        if (vsel_rearm) state_d = ST_NORM;
      end
      default: state_d = ST_NORM;
    endcase
  end

  always_comb begin
    if (state_d != state_q) hit_d = (state_d == ST_ONW);
    else                    hit_d = hit_q | ovl_det;
  end

  assign tmr_clr   = (state_d != state_q);
  assign tmr_limit = (state_q == ST_OFFW) ? TW'(TOFF_TICKS) : TW'(TON_TICKS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_NORM;
      hit_q    <= 1'b0;
      out_en   <= 1'b1;
      fault_n  <= 1'b1;
      olf_set  <= 1'b0;
      vsel_clr <= 1'b0;
    end else begin
      state_q  <= state_d;
      hit_q    <= hit_d;
      out_en   <= !((state_d == ST_OFFW) || (state_d == ST_LOCK));
      fault_n  <= (state_d == ST_NORM);
      olf_set  <= (state_q == ST_NORM) && (state_d != ST_NORM);
      vsel_clr <= (state_d == ST_LOCK) && (state_q != ST_LOCK);
    end
  end

  // R10: an off-window is never cut short
  p_off_full_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OFFW && !tmr_done) |=> (state_q == ST_OFFW));
  // R7: static detection keeps the output on and flags a fault
  p_static_keeps_on_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NORM && ovl_det && pcl_static) |=> (out_en && !fault_n));
  // R8: a locked channel leaves only through rearm
  p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCK && !vsel_rearm) |=> (state_q == ST_LOCK));

endmodule

// File: rtl/olp_ctrl.sv
`timescale 1ns/1ps
module olp_ctrl
  import olp_pkg::*;
#(
  parameter int TON_TICKS  = 90,
  parameter int TOFF_TICKS = 900,
  parameter int HOLD_CYC   = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic ovl_raw,
  input  logic pcl_static,
  input  logic olr_latch,
  input  logic vsel_rearm,
  output logic out_en,
  output logic olf_set,
  output logic vsel_clr,
  output logic fault_n
);
  localparam int MAXT = max2(TON_TICKS, TOFF_TICKS);
  localparam int TW   = $clog2(MAXT + 1);

  logic          ovl_det;
  logic          tmr_clr;
  logic          tmr_done;
  logic [TW-1:0] tmr_limit;

  olp_ovl_filter #(.HOLD_CYC(HOLD_CYC)) u_filter (
    .clk     (clk),
    .rst     (rst),
    .ovl_raw (ovl_raw),
    .ovl_det (ovl_det)
  );

  olp_tick_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (tmr_clr),
    .tick  (tick),
    .limit (tmr_limit),
    .done  (tmr_done)
  );

  olp_fsm #(
    .TON_TICKS  (TON_TICKS),
    .TOFF_TICKS (TOFF_TICKS),
    .TW         (TW)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ovl_det    (ovl_det),
    .pcl_static (pcl_static),
    .olr_latch  (olr_latch),
    .vsel_rearm (vsel_rearm),
    .tmr_done   (tmr_done),
    .tmr_clr    (tmr_clr),
    .tmr_limit  (tmr_limit),
    .out_en     (out_en),
    .fault_n    (fault_n),
    .olf_set    (olf_set),
    .vsel_clr   (vsel_clr)
  );

  // R4: the output is only blocked while a fault is flagged
  p_off_means_fault_r4: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> !fault_n);
  // R3: diagnostic request is a single-cycle pulse
  p_olf_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    olf_set |=> !olf_set);
  // R8: field clear comes with a disabled output
  p_clr_disables_r8: assert property (@(posedge clk) disable iff (rst)
    vsel_clr |-> (!out_en && !fault_n));

endmodule

// File: tb/olp_ctrl_tb.sv
`timescale 1ns/1ps
module olp_ctrl_tb;
  localparam int TON  = 8;
  localparam int TOFF = 20;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst, tick, ovl_raw, pcl_static, olr_latch, vsel_rearm;
  logic out_en, olf_set, vsel_clr, fault_n;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  olp_ctrl #(.TON_TICKS(TON), .TOFF_TICKS(TOFF), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst(rst), .tick(tick), .ovl_raw(ovl_raw),
    .pcl_static(pcl_static), .olr_latch(olr_latch), .vsel_rearm(vsel_rearm),
    .out_en(out_en), .olf_set(olf_set), .vsel_clr(vsel_clr), .fault_n(fault_n)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic pcl, input logic olr);
    @(negedge clk);
    rst = 1'b1; tick = 1'b1; ovl_raw = 1'b0; vsel_rearm = 1'b0;
    pcl_static = pcl; olr_latch = olr;
    step(2);
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    chk("R1", "out_en", out_en, 1'b1);
    chk("R1", "fault_n", fault_n, 1'b1);
    chk("R1", "olf_set", olf_set, 1'b0);
    chk("R1", "vsel_clr", vsel_clr, 1'b0);
  endtask

  task automatic t_glitch();
    logic seen = 1'b0;
    do_reset(1'b0, 1'b0);
    ovl_raw = 1'b1;
    step(HOLD - 1);
    ovl_raw = 1'b0;
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (olf_set || !fault_n || !out_en) seen = 1'b1;
    end
    chk("R2", "short pulse ignored", seen, 1'b0);
    ovl_raw = 1'b1;
    step(HOLD);
    ovl_raw = 1'b0;
    step(3);
    chk("R2", "held pulse detected", olf_set, 1'b1);
  endtask

  task automatic t_dyn_persist();
    do_reset(1'b0, 1'b0);
    ovl_raw = 1'b1;
    step(HOLD + 2);
    chk("R2", "no olf before latency", olf_set, 1'b0);
    step(1);
    chk("R3", "olf_set pulse", olf_set, 1'b1);
    chk("R3", "fault_n low", fault_n, 1'b0);
    chk("R4", "on during TON", out_en, 1'b1);
    step(1);
    chk("R3", "olf_set one cycle", olf_set, 1'b0);
    step(TON - 2);
    chk("R4", "still on at TON-1", out_en, 1'b1);
    step(1);
    chk("R4", "off after TON", out_en, 1'b0);
    step(TOFF - 1);
    chk("R4", "off until TOFF", out_en, 1'b0);
    step(1);
    chk("R5", "retry on", out_en, 1'b1);
    step(TON - 1);
    chk("R5", "retry on to end", out_en, 1'b1);
    step(1);
    chk("R5", "off again", out_en, 1'b0);
    ovl_raw = 1'b0;
  endtask

  task automatic t_dyn_recover();
    do_reset(1'b0, 1'b0);
    ovl_raw = 1'b1;
    step(HOLD + 3 + TON + 5);
    ovl_raw = 1'b0;
    step(TOFF - 5);
    chk("R5", "retry on", out_en, 1'b1);
    chk("R6", "fault during retry", fault_n, 1'b0);
    step(TON);
    chk("R6", "normal out_en", out_en, 1'b1);
    chk("R6", "normal fault_n", fault_n, 1'b1);
    chk("R6", "no field clear", vsel_clr, 1'b0);
  endtask

  task automatic t_dyn_lock();
    do_reset(1'b0, 1'b1);
    ovl_raw = 1'b1;
    step(HOLD + 3 + TON + 5);
    ovl_raw = 1'b0;
    step(TOFF - 5 + TON);
    chk("R8", "vsel_clr pulse", vsel_clr, 1'b1);
    chk("R8", "locked off", out_en, 1'b0);
    step(1);
    chk("R8", "vsel_clr one cycle", vsel_clr, 1'b0);
    step(5);
    chk("R8", "stays off", out_en, 1'b0);
    chk("R8", "fault held", fault_n, 1'b0);
    vsel_rearm = 1'b1;
    step(1);
    vsel_rearm = 1'b0;
    chk("R8", "rearm on", out_en, 1'b1);
    chk("R8", "rearm fault_n", fault_n, 1'b1);
    vsel_rearm = 1'b1;
    step(1);
    vsel_rearm = 1'b0;
    step(1);
    chk("R8", "rearm ignored out_en", out_en, 1'b1);
    chk("R8", "rearm ignored vsel_clr", vsel_clr, 1'b0);
  endtask

  task automatic t_static();
    do_reset(1'b1, 1'b0);
    ovl_raw = 1'b1;
    step(HOLD + 3);
    chk("R3", "static olf_set", olf_set, 1'b1);
    chk("R7", "static fault_n", fault_n, 1'b0);
    step(43);
    chk("R7", "static stays on", out_en, 1'b1);
    chk("R7", "static fault held", fault_n, 1'b0);
    ovl_raw = 1'b0;
    step(3);
    chk("R7", "fault until det clears", fault_n, 1'b0);
    step(1);
    chk("R7", "fault released", fault_n, 1'b1);
    chk("R7", "still on", out_en, 1'b1);
    do_reset(1'b1, 1'b1);
    ovl_raw = 1'b1;
    step(HOLD + 3 + 10);
    ovl_raw = 1'b0;
    step(4);
    chk("R8", "static lock clr", vsel_clr, 1'b1);
    chk("R8", "static lock off", out_en, 1'b0);
    vsel_rearm = 1'b1;
    step(1);
    vsel_rearm = 1'b0;
    chk("R8", "static rearm", out_en, 1'b1);
  endtask

  task automatic t_tick();
    do_reset(1'b0, 1'b0);
    tick = 1'b0;
    ovl_raw = 1'b1;
    step(40);
    chk("R9", "no tick no end", out_en, 1'b1);
    chk("R9", "window active", fault_n, 1'b0);
    tick = 1'b1;
    step(TON - 1);
    chk("R9", "on before last tick", out_en, 1'b1);
    step(1);
    chk("R9", "off after TON ticks", out_en, 1'b0);
    ovl_raw = 1'b0;
  endtask

  task automatic t_pcl_switch();
    do_reset(1'b0, 1'b0);
    ovl_raw = 1'b1;
    step(HOLD + 3 + TON + 5);
    pcl_static = 1'b1;
    step(TOFF - 6);
    chk("R10", "off not shortened", out_en, 1'b0);
    step(1);
    chk("R10", "retry on", out_en, 1'b1);
    step(TON);
    chk("R10", "clamp keeps on", out_en, 1'b1);
    chk("R10", "clamp fault", fault_n, 1'b0);
    step(5);
    chk("R10", "clamp still on", out_en, 1'b1);
    pcl_static = 1'b0;
    step(TON);
    chk("R10", "fresh window on", out_en, 1'b1);
    step(1);
    chk("R10", "fresh window off", out_en, 1'b0);
    ovl_raw = 1'b0;
  endtask

  initial begin
    rst = 1'b1; tick = 1'b1; ovl_raw = 1'b0; pcl_static = 1'b0;
    olr_latch = 1'b0; vsel_rearm = 1'b0;
    t_reset();
    t_glitch();
    t_dyn_persist();
    t_dyn_recover();
    t_dyn_lock();
    t_static();
    t_tick();
    t_pcl_switch();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule